// File: doc/BRIEF.md
# Bank-Aware Request Admission Gate

This block sits at the front of a multi-bank memory controller, before the scheduler. Every read or write request carries a bank index. The gate keeps a live count of outstanding requests for each bank and a running total across all banks. A request is granted only while the total stays within a configured ceiling. A granted request is acknowledged to the requester and pushed into the scheduler queue. One cycle after the push, the gate pulses a scheduling-attempt strobe.

When a request would take the total past the ceiling, the gate parks it in a single hold slot. The request is counted but not acknowledged. Nothing more is accepted until a response completes. At that point the parked request is granted and the slot empties.

Each entry raises a one-hot wake pulse for its bank. Each completed response raises a one-hot sleep pulse for its bank. A power-down manager uses these pulses together with the per-bank counts.

Top module: `req_admit_top`

## Requirements
- R1: A request accepted at clock edge k (reqValid and reqReady both high) is evaluated at edge k+1. A grant for it is visible on ackValid, schedPush, schedBank and schedWrite in the cycle after edge k+1, for exactly one cycle.
- R2: At the evaluation edge, the request's bank count increments by one. This happens before the ceiling check, whether the request is granted or held. In the same cycle, wakeEvt shows a one-hot pulse with bit i meaning bank i.
- R3: The evaluated request is granted when the total, including this cycle's increment and any simultaneous response decrement, is at most MAX_OUT. The total may reach MAX_OUT exactly without a hold. issueTry pulses in the cycle after each grant.
- R4: When that total exceeds MAX_OUT, the request produces no ackValid and no schedPush. It is parked in the hold slot, and its count stays included.
- R5: reqReady is low while the hold slot is full. It is also low in a cycle where the staged request is about to be parked. A request presented while reqReady is low leaves all counts and outputs untouched.
- R6: A response completion (rspDone) while the slot is full grants the parked request, with its own bank and write flag, at that edge. issueTry follows one cycle later, and reqReady returns high.
- R7: rspDone decrements the count of bank rspBank. One cycle after the decrement, sleepTrig pulses one-hot with bit rspBank.
- R8: An entry evaluation and a response on the same bank in the same cycle leave that bank's count unchanged. totalOut always equals the sum of the bankCnt fields, where bank i occupies bits [i*CNT_W +: CNT_W].
- R9: After reset, all counts and pulses are zero, the slot is empty and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqBank | input | BANK_W | Bank index of the offered request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqReady | output | 1 | Gate can take a request this cycle |
| rspDone | input | 1 | A response handshake completed |
| rspBank | input | BANK_W | Bank of the completed response |
| ackValid | output | 1 | OK acknowledgment to the requester |
| schedPush | output | 1 | Push strobe into the scheduler queue |
| schedBank | output | BANK_W | Bank of the pushed request |
| schedWrite | output | 1 | Write flag of the pushed request |
| issueTry | output | 1 | Ask the scheduler to try issuing the next request |
| wakeEvt | output | NUM_BANKS | One-hot entry pulse per bank |
| sleepTrig | output | NUM_BANKS | One-hot sleep-trigger pulse per bank |
| totalOut | output | TOT_W | Outstanding requests over all banks |
| bankCnt | output | NUM_BANKS*CNT_W | Outstanding count per bank, packed |

## Verification
The bench drives the total to exactly the ceiling and checks that no hold occurs. It then goes one past the ceiling. A gate that checked the limit before incrementing, or that compared with greater-or-equal, would park one request too early or one too late. Requests offered while the slot is full are checked to leave every count and pulse untouched. A gate whose ready ignored the slot would lose requests or double-count them. The release path is checked for the parked request's own bank and write flag. A same-bank entry and exit in one cycle is checked for an unchanged count, which a gate that let one update win would get wrong. A long pseudo-random phase compares every output against the behavioural model on each cycle.

// File: rtl/req_admit_pkg.sv
package req_admit_pkg;

  // Strobes the control side hands to the counting datapath each cycle.
  typedef struct packed {
    logic incEn;   // a staged request is being evaluated
    logic decEn;   // a response completed
  } cnt_strobe_t;

  // State of the single parking slot.
  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_state_t;

endpackage

// File: rtl/req_admit_cnt.sv
module req_admit_cnt
  import req_admit_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int TOT_W    = CNT_W + BANK_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cnt_strobe_t                strobe,
  input  logic [BANK_W-1:0]          incBank,
  input  logic [BANK_W-1:0]          decBank,
  output logic [TOT_W-1:0]           totalQ,
  output logic [TOT_W-1:0]           totalNext,
  output logic [NUM_BANKS*CNT_W-1:0] bankCnt,
  output logic [NUM_BANKS-1:0]       wakeEvt,
  output logic [NUM_BANKS-1:0]       sleepTrig
);

  logic [NUM_BANKS-1:0] sleepPend;

  // Projected total: entry counted first, then any completion removed.
  assign totalNext = totalQ + TOT_W'(strobe.incEn) - TOT_W'(strobe.decEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      totalQ <= '0;
    end else begin
      totalQ <= totalNext;
    end
  end

  // One counter per bank.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cntQ;
    logic incHit;
    logic decHit;

    assign incHit = strobe.incEn && (incBank == BANK_W'(b));
    assign decHit = strobe.decEn && (decBank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
      end else begin
        unique case ({incHit, decHit})
          2'b10:   cntQ <= cntQ + 1'b1;
          2'b01:   cntQ <= cntQ - 1'b1;
          default: cntQ <= cntQ;
        endcase
      end
    end

    assign bankCnt[b*CNT_W +: CNT_W] = cntQ;
  end

  // Entry pulse at the evaluation edge. The sleep pulse lags the decrement
  // by a cycle, so the manager sees the lowered count along with it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeEvt   <= '0;
      sleepPend <= '0;
      sleepTrig <= '0;
    end else begin
      wakeEvt   <= strobe.incEn ? (NUM_BANKS'(1) << incBank) : '0;
      sleepPend <= strobe.decEn ? (NUM_BANKS'(1) << decBank) : '0;
      sleepTrig <= sleepPend;
    end
  end

endmodule

// File: rtl/req_admit_ctrl.sv
module req_admit_ctrl
  import req_admit_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 4,
  parameter int MAX_OUT   = 6,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int TOT_W    = CNT_W + BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] reqBank,
  input  logic              reqWrite,
  output logic              reqReady,
  input  logic              rspDone,
  input  logic [BANK_W-1:0] rspBank,
  input  logic [TOT_W-1:0]  totalNext,
  output cnt_strobe_t       strobe,
  output logic [BANK_W-1:0] incBank,
  output logic [BANK_W-1:0] decBank,
  output logic              grantValid,
  output logic [BANK_W-1:0] grantBank,
  output logic              grantWrite,
  output logic              issueTry,
  output logic              slotFull
);

  // Alignment stage: one register between the port and the evaluation.
  logic              stgValidQ;
  logic [BANK_W-1:0] stgBankQ;
  logic              stgWriteQ;

  slot_state_t       slotQ;
  logic [BANK_W-1:0] holdBankQ;
  logic              holdWriteQ;

  logic overLimit;
  logic holdNow;
  logic releaseNow;
  logic accept;

  assign overLimit  = totalNext > TOT_W'(MAX_OUT);
  assign holdNow    = stgValidQ && overLimit;
  assign releaseNow = (slotQ == SLOT_FULL) && rspDone;
  assign slotFull   = (slotQ == SLOT_FULL);

  assign reqReady = (slotQ == SLOT_EMPTY) && !holdNow;
  assign accept   = reqValid && reqReady;

  assign strobe.incEn = stgValidQ;
  assign strobe.decEn = rspDone;
  assign incBank      = stgBankQ;
  assign decBank      = rspBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgValidQ <= 1'b0;
      stgBankQ  <= '0;
      stgWriteQ <= 1'b0;
    end else begin
      stgValidQ <= accept;
      if (accept) begin
        stgBankQ  <= reqBank;
        stgWriteQ <= reqWrite;
      end
    end
  end

  // The slot fills only from the stage. It empties only on a response.
  // Both cannot happen together: a full slot keeps the stage empty.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ      <= SLOT_EMPTY;
      holdBankQ  <= '0;
      holdWriteQ <= 1'b0;
    end else if (holdNow) begin
      slotQ      <= SLOT_FULL;
      holdBankQ  <= stgBankQ;
      holdWriteQ <= stgWriteQ;
    end else if (releaseNow) begin
      slotQ      <= SLOT_EMPTY;
    end
  end

  // Grant register feeds both the acknowledgment and the scheduler push.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantBank  <= '0;
      grantWrite <= 1'b0;
      issueTry   <= 1'b0;
    end else begin
      issueTry <= grantValid;
      if (stgValidQ && !overLimit) begin
        grantValid <= 1'b1;
        grantBank  <= stgBankQ;
        grantWrite <= stgWriteQ;
      end else if (releaseNow) begin
        grantValid <= 1'b1;
        grantBank  <= holdBankQ;
        grantWrite <= holdWriteQ;
      end else begin
        grantValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/req_admit_top.sv
module req_admit_top
  import req_admit_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 4,
  parameter int MAX_OUT   = 6,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int TOT_W    = CNT_W + BANK_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [BANK_W-1:0]          reqBank,
  input  logic                       reqWrite,
  output logic                       reqReady,
  input  logic                       rspDone,
  input  logic [BANK_W-1:0]          rspBank,
  output logic                       ackValid,
  output logic                       schedPush,
  output logic [BANK_W-1:0]          schedBank,
  output logic                       schedWrite,
  output logic                       issueTry,
  output logic [NUM_BANKS-1:0]       wakeEvt,
  output logic [NUM_BANKS-1:0]       sleepTrig,
  output logic [TOT_W-1:0]           totalOut,
  output logic [NUM_BANKS*CNT_W-1:0] bankCnt
);

  cnt_strobe_t       strobe;
  logic [BANK_W-1:0] incBank;
  logic [BANK_W-1:0] decBank;
  logic [TOT_W-1:0]  totalNext;
  logic              grantValid;
  logic              slotFull;

  req_admit_ctrl #(
    .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .MAX_OUT(MAX_OUT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqBank(reqBank), .reqWrite(reqWrite),
    .reqReady(reqReady), .rspDone(rspDone), .rspBank(rspBank),
    .totalNext(totalNext), .strobe(strobe),
    .incBank(incBank), .decBank(decBank),
    .grantValid(grantValid), .grantBank(schedBank), .grantWrite(schedWrite),
    .issueTry(issueTry), .slotFull(slotFull)
  );

  req_admit_cnt #(
    .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)
  ) cnt_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .incBank(incBank), .decBank(decBank),
    .totalQ(totalOut), .totalNext(totalNext), .bankCnt(bankCnt),
    .wakeEvt(wakeEvt), .sleepTrig(sleepTrig)
  );

  assign ackValid  = grantValid;
  assign schedPush = grantValid;

endmodule

// File: rtl/req_admit_chk.sv
module req_admit_chk #(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 4,
  parameter int MAX_OUT   = 6,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int TOT_W    = CNT_W + BANK_W
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       reqValid,
  input logic                       reqReady,
  input logic                       rspDone,
  input logic [BANK_W-1:0]          rspBank,
  input logic                       ackValid,
  input logic [NUM_BANKS-1:0]       wakeEvt,
  input logic [NUM_BANKS-1:0]       sleepTrig,
  input logic [TOT_W-1:0]           totalOut,
  input logic [NUM_BANKS*CNT_W-1:0] bankCnt,
  input logic                       slotFull
);

  logic [TOT_W-1:0] cntSum;
  always_comb begin
    cntSum = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      cntSum = cntSum + TOT_W'(bankCnt[b*CNT_W +: CNT_W]);
    end
  end

  AST_ENTRY_RESOLVES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> ##1 ((ackValid || slotFull) && $countones(wakeEvt) == 1)); // R1

  AST_TOTAL_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    totalOut <= TOT_W'(MAX_OUT + 1)); // R4

  AST_SLOT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    slotFull |-> !reqReady); // R5

  AST_RELEASE_GRANTS: assert property (@(posedge clk) disable iff (!rstN)
    (slotFull && rspDone) |=> (ackValid && !slotFull)); // R6

  AST_SLEEP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> ##1 (sleepTrig == (NUM_BANKS'(1) << $past(rspBank, 2)))); // R7

  AST_TOTAL_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    totalOut == cntSum); // R8

endmodule

bind req_admit_top req_admit_chk #(
  .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .MAX_OUT(MAX_OUT)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspDone(rspDone), .rspBank(rspBank), .ackValid(ackValid),
  .wakeEvt(wakeEvt), .sleepTrig(sleepTrig), .totalOut(totalOut),
  .bankCnt(bankCnt), .slotFull(slotFull)
);

// File: tb/req_admit_top_tb_top.sv
module req_admit_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB    = 8;
  localparam int CW    = 4;
  localparam int MAXO  = 6;
  localparam int BW    = 3;
  localparam int TW    = CW + BW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [BW-1:0] reqBank = '0;
  logic reqWrite = 1'b0;
  logic reqReady;
  logic rspDone = 1'b0;
  logic [BW-1:0] rspBank = '0;
  logic ackValid, schedPush, schedWrite, issueTry;
  logic [BW-1:0] schedBank;
  logic [NB-1:0] wakeEvt, sleepTrig;
  logic [TW-1:0] totalOut;
  logic [NB*CW-1:0] bankCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  req_admit_top #(.NUM_BANKS(NB), .CNT_W(CW), .MAX_OUT(MAXO)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank),
    .reqWrite(reqWrite), .reqReady(reqReady), .rspDone(rspDone),
    .rspBank(rspBank), .ackValid(ackValid), .schedPush(schedPush),
    .schedBank(schedBank), .schedWrite(schedWrite), .issueTry(issueTry),
    .wakeEvt(wakeEvt), .sleepTrig(sleepTrig), .totalOut(totalOut),
    .bankCnt(bankCnt)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // Behavioural reference state
  int mCnt[NB];
  int mTotal = 0;
  bit mStgV = 0; int mStgB = 0; bit mStgW = 0;
  bit mHeld = 0; int mHB = 0; bit mHW = 0;
  bit eAck = 0; int eAckB = 0; bit eAckW = 0;
  bit eIssue = 0;
  int eWake = 0; int eSleep = 0; int mSleepPend = 0;
  bit lastAcc = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareOutputs();
    chk("R1 R3 R4 ackValid", ackValid, eAck);
    chk("R1 R3 schedPush", schedPush, eAck);
    if (eAck) begin
      chk("R6 schedBank", schedBank, eAckB);
      chk("R6 schedWrite", schedWrite, eAckW);
    end
    chk("R3 issueTry", issueTry, eIssue);
    chk("R2 wakeEvt", wakeEvt, eWake);
    chk("R7 sleepTrig", sleepTrig, eSleep);
    chk("R8 totalOut", totalOut, mTotal);
    for (int b = 0; b < NB; b++)
      chk("R2 R8 bankCnt", bankCnt[b*CW +: CW], mCnt[b]);
  endtask

  task automatic stepCyc(input bit rv, input int rb, input bit rw,
                         input bit rd, input int rk);
    int inc, dec, newTot;
    bit rdy;
    bit nAck, nAckW, nHeld, nHW;
    int nAckB, nHB;
    @(negedge clk);
    compareOutputs();
    reqValid = rv; reqBank = BW'(rb); reqWrite = rw;
    rspDone = rd; rspBank = BW'(rk);
    #1;
    inc = mStgV ? 1 : 0;
    dec = rd ? 1 : 0;
    newTot = mTotal + inc - dec;
    rdy = !mHeld && !(mStgV && newTot > MAXO);
    chk("R5 reqReady", reqReady, rdy);
    lastAcc = rv && rdy;
    nAck = 0; nAckB = eAckB; nAckW = eAckW;
    nHeld = mHeld; nHB = mHB; nHW = mHW;
    if (mStgV) begin
      if (newTot > MAXO) begin nHeld = 1; nHB = mStgB; nHW = mStgW; end
      else begin nAck = 1; nAckB = mStgB; nAckW = mStgW; end
    end else if (mHeld && rd) begin
      nAck = 1; nAckB = mHB; nAckW = mHW; nHeld = 0;
    end
    eIssue = eAck;
    eSleep = mSleepPend;
    mSleepPend = rd ? (1 << rk) : 0;
    eWake = mStgV ? (1 << mStgB) : 0;
    if (mStgV) mCnt[mStgB]++;
    if (rd) mCnt[rk]--;
    mTotal = newTot;
    eAck = nAck; eAckB = nAckB; eAckW = nAckW;
    mHeld = nHeld; mHB = nHB; mHW = nHW;
    mStgV = lastAcc;
    if (lastAcc) begin mStgB = rb; mStgW = rw; end
  endtask

  task automatic sendReq(input int b, input bit w);
    for (int t = 0; t < 40; t++) begin
      stepCyc(1, b, w, 0, 0);
      if (lastAcc) break;
    end
  endtask

  task automatic idle(input int n);
    for (int t = 0; t < n; t++) stepCyc(0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    for (int b = 0; b < NB; b++) mCnt[b] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R9: reset state
    chk("R9 reqReady after reset", reqReady, 1);
    chk("R9 totalOut after reset", totalOut, 0);
    chk("R9 ackValid after reset", ackValid, 0);
    chk("R9 pulses after reset", {wakeEvt, sleepTrig}, 0);

    // R1: single request, two-edge latency
    sendReq(2, 1);
    @(posedge clk); #2;
    chk("R1 no grant one edge after accept", ackValid, 0);
    idle(3);

    // R3: fill to exactly the ceiling (already 1 outstanding)
    for (int b = 0; b < 5; b++) sendReq(b, b[0]);
    idle(3);
    @(posedge clk); #2;
    chk("R3 total at ceiling without hold", totalOut, MAXO);
    chk("R3 ready at ceiling", reqReady, 1);

    // R4: one past the ceiling is parked
    sendReq(7, 1);
    idle(2);
    @(posedge clk); #2;
    chk("R4 parked request counted", totalOut, MAXO + 1);
    chk("R4 ready low while parked", reqReady, 0);

    // R5: requests offered while parked are ignored
    for (int t = 0; t < 3; t++) begin
      stepCyc(1, 3, 0, 0, 0);
      chk("R5 offered request not taken", lastAcc, 0);
    end
    idle(1);

    // R6: a completion on bank 2 releases the parked bank-7 write
    stepCyc(0, 0, 0, 1, 2);
    @(posedge clk); #2;
    chk("R6 release ack", ackValid, 1);
    chk("R6 release bank", schedBank, 7);
    chk("R6 release write", schedWrite, 1);
    idle(3);

    // Drain two to make room, then R8 same-bank entry/exit
    stepCyc(0, 0, 0, 1, 0);
    stepCyc(0, 0, 0, 1, 1);
    idle(2);
    sendReq(4, 0);
    stepCyc(0, 0, 0, 1, 4);
    @(posedge clk); #2;
    chk("R8 same-bank entry and exit", bankCnt[4*CW +: CW], 1);
    idle(4);

    // Pseudo-random mix
    lfsr = 16'hACE1;
    for (int i = 0; i < 800; i++) begin
      bit rv, rd;
      int rb, rk;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rv = lfsr[0] | lfsr[1];
      rb = int'(lfsr[4:2]);
      rk = int'(lfsr[9:7]);
      rd = lfsr[5] && (mCnt[rk] > 0);
      stepCyc(rv, rb, lfsr[6], rd, rk);
    end
    idle(4);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule